// File: doc/BRIEF.md
# Loop Bandwidth Mode Controller

This block decides whether an external phase-locked loop runs with a narrow or a wide loop bandwidth. It runs on a synchronous controller clock. It looks at its inputs only in the cycle marked by a one-cycle strobe, which the phase detector raises once per comparison. At each strobe it updates a count of consecutive comparisons taken with the loss-of-lock flag low. The count saturates at a parameterised limit, eight by default. From that count and the control levels, a small state machine selects the bandwidth.

The block has two ways to reach narrow bandwidth.

- **Power-up acquisition.** A narrow request takes effect only after the loop has shown a run of clean comparisons. From then on the loop stays narrow.
- **Hitless switching.** With no narrow request, this option arms after a clean run. Any later loss-of-lock comparison drops the loop to narrow bandwidth while it reacquires. The loop returns to wide, and the option re-arms, after another clean run.

An initialization-enable level that is held low forces wide bandwidth under all conditions. The output is registered and changes only after a strobe cycle.

Top module: `loop_bw_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the clean-run count and selects wide bandwidth (`narrow_sel` = 0, where 1 means narrow), starting from the cycle after the reset edge.
- R2: Inputs are sampled only in cycles where `pd_strobe` is 1. In a cycle without a strobe, `narrow_sel` holds its value whatever the other inputs do.
- R3: With `narrow_req`=1 and `init_en`=1, `narrow_sel` stays 0 through the first seven clean strobes. It becomes 1 in the cycle after the eighth consecutive strobe taken with `lol`=0.
- R4: A strobe taken with `lol`=1 resets the clean-run count to zero. The full run of eight clean strobes must then be repeated.
- R5: A strobe taken with `init_en`=0 makes `narrow_sel` 0 in the next cycle, whatever the other inputs are.
- R6: While `narrow_req`=1 and `init_en`=1, once `narrow_sel` is 1 it stays 1 through loss-of-lock strobes, and `hitless_en` has no effect.
- R7: With `narrow_req`=0, `hitless_en`=1 and `init_en`=1, a loss-of-lock strobe leaves `narrow_sel` at 0 until hitless switching has been armed by eight consecutive clean strobes.
- R8: Once hitless switching is armed, a single strobe with `lol`=1 makes `narrow_sel` 1 in the next cycle.
- R9: After a hitless trigger, `narrow_sel` stays 1 until eight consecutive clean strobes have been seen, and then returns to 0. The function is then re-armed, so the next loss-of-lock strobe triggers it again.
- R10: With `narrow_req`=0 and `hitless_en`=0, `narrow_sel` stays 0 for every pattern of `lol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_strobe | input | 1 | One-cycle pulse, once per phase comparison |
| lol | input | 1 | Loss-of-lock flag for the comparison marked by the strobe |
| narrow_req | input | 1 | Request for narrow loop bandwidth |
| init_en | input | 1 | Initialization enable; 0 forces wide bandwidth |
| hitless_en | input | 1 | Enables hitless switching |
| narrow_sel | output | 1 | 1 = narrow bandwidth, 0 = wide bandwidth |

## Verification
The hardest situation to reach from the ports is a re-armed hitless function. Getting there takes a clean run to arm, a single loss-of-lock strobe to trigger, a loss-of-lock strobe in the middle of the recovery that must restart the run, and a complete second run. Only after all of that does a new loss-of-lock strobe show the re-armed trigger. The bench drives this as one long strobe sequence inside a single task. It checks `narrow_sel` after every strobe, so an off-by-one in the run length, or a count that is not cleared, shows up at the exact strobe where it occurs.

// File: rtl/bwmode_pkg.sv
package bwmode_pkg;

  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,  // wide, waiting for a clean run
    ST_HELD  = 2'd1,  // narrow by request, held
    ST_ARMED = 2'd2,  // wide, hitless armed
    ST_HIT   = 2'd3   // narrow while reacquiring after a hitless trigger
  } bw_state_e;

  // Saturating clean-run step: a flagged comparison restarts the run.
  function automatic int unsigned step_run(input int unsigned cur,
                                           input logic lol_flag,
                                           input int unsigned limit);
    if (lol_flag)        return 0;
    if (cur >= limit)    return limit;
    return cur + 1;
  endfunction

  // Mode decision taken at each comparison strobe.
  function automatic bw_state_e next_mode(input bw_state_e cur,
                                          input logic req,
                                          input logic init,
                                          input logic hit_en,
                                          input logic lol_flag,
                                          input logic run_done);
    if (!init) return ST_ACQ;
    if (req) begin
      if (cur == ST_HELD || run_done) return ST_HELD;
      return ST_ACQ;
    end
    if (!hit_en) return ST_ACQ;
    case (cur)
      ST_HIT:   return run_done ? ST_ARMED : ST_HIT;
      ST_ARMED: return lol_flag ? ST_HIT : ST_ARMED;
      default:  return run_done ? ST_ARMED : ST_ACQ;
    endcase
  endfunction

  function automatic logic mode_is_narrow(input bw_state_e s);
    return (s == ST_HELD) || (s == ST_HIT);
  endfunction

endpackage

// File: rtl/bw_lock_counter.sv
module bw_lock_counter #(
  parameter int LOCK_CYCLES = 8,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic lol_i,
  output logic run_done_next_o
);
  import bwmode_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_d = CNT_W'(step_run(32'(cnt_q), lol_i, LOCK_CYCLES));
  assign run_done_next_o = (cnt_d == CNT_W'(LOCK_CYCLES));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (strobe_i) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LOCK_CYCLES));

  assert_lol_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && lol_i) |=> (cnt_q == '0));

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(cnt_q));

endmodule

// File: rtl/bw_mode_fsm.sv
module bw_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic lol_i,
  input  logic narrow_req_i,
  input  logic init_en_i,
  input  logic hitless_en_i,
  input  logic run_done_next_i,
  output logic narrow_o
);
  import bwmode_pkg::*;

  bw_state_e state_q;
  bw_state_e state_d;
  logic      hit_event;   // armed hitless function sees a phase error

  assign state_d   = next_mode(state_q, narrow_req_i, init_en_i,
                               hitless_en_i, lol_i, run_done_next_i);
  assign hit_event = strobe_i && (state_q == ST_ARMED) && lol_i &&
                     init_en_i && !narrow_req_i && hitless_en_i;
  assign narrow_o  = mode_is_narrow(state_q);

  always_ff @(posedge clk) begin
    if (rst)           state_q <= ST_ACQ;
    else if (strobe_i) state_q <= state_d;
  end

  assert_reset_wide_R1: assert property (@(posedge clk)
    rst |=> !narrow_o);

  assert_out_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(narrow_o));

  assert_init_forces_wide_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !init_en_i) |=> !narrow_o);

  assert_held_narrow_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && narrow_o && narrow_req_i && init_en_i) |=> narrow_o);

  assert_unarmed_wide_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && state_q == ST_ACQ && !run_done_next_i && !narrow_req_i)
      |=> !narrow_o);

  assert_hit_trigger_R8: assert property (@(posedge clk) disable iff (rst)
    hit_event |=> narrow_o);

  assert_no_hitless_wide_R10: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !narrow_req_i && !hitless_en_i) |=> !narrow_o);

endmodule

// File: rtl/loop_bw_ctrl.sv
module loop_bw_ctrl #(
  parameter int LOCK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_strobe,
  input  logic lol,
  input  logic narrow_req,
  input  logic init_en,
  input  logic hitless_en,
  output logic narrow_sel
);

  logic run_done_next;

  bw_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES)) cnt_i (
    .clk             (clk),
    .rst             (rst),
    .strobe_i        (pd_strobe),
    .lol_i           (lol),
    .run_done_next_o (run_done_next)
  );

  bw_mode_fsm fsm_i (
    .clk             (clk),
    .rst             (rst),
    .strobe_i        (pd_strobe),
    .lol_i           (lol),
    .narrow_req_i    (narrow_req),
    .init_en_i       (init_en),
    .hitless_en_i    (hitless_en),
    .run_done_next_i (run_done_next),
    .narrow_o        (narrow_sel)
  );

  // R9: leaving hitless recovery needs a full clean run (checked via counter)
  assert_recover_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    (pd_strobe && narrow_sel && !narrow_req && init_en && hitless_en &&
     !run_done_next) |=> narrow_sel);

endmodule

// File: tb/loop_bw_ctrl_tb_top.sv
module loop_bw_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_strobe = 1'b0;
  logic lol = 1'b0;
  logic narrow_req = 1'b0;
  logic init_en = 1'b0;
  logic hitless_en = 1'b0;
  logic narrow_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_bw_ctrl dut_i (
    .clk(clk), .rst(rst), .pd_strobe(pd_strobe), .lol(lol),
    .narrow_req(narrow_req), .init_en(init_en), .hitless_en(hitless_en),
    .narrow_sel(narrow_sel)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one comparison strobe; returns at the negedge after the updating edge
  task automatic pulse(input logic l);
    @(negedge clk);
    lol = l; pd_strobe = 1'b1;
    @(negedge clk);
    pd_strobe = 1'b0; lol = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    narrow_req = 1'b1; init_en = 1'b1;
    do_reset();
    chk(narrow_sel, 1'b0, "R1 reset selects wide");
  endtask

  task automatic t_acquire();
    do_reset();
    narrow_req = 1'b1; init_en = 1'b1; hitless_en = 1'b0;
    for (int i = 0; i < 7; i++) begin
      pulse(1'b0);
      chk(narrow_sel, 1'b0, "R3 wide before eight clean strobes");
    end
    pulse(1'b0);
    chk(narrow_sel, 1'b1, "R3 narrow after eighth clean strobe");
  endtask

  task automatic t_restart();
    do_reset();
    narrow_req = 1'b1; init_en = 1'b1;
    for (int i = 0; i < 5; i++) pulse(1'b0);
    pulse(1'b1);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    chk(narrow_sel, 1'b0, "R4 run restarted by lol");
    pulse(1'b0);
    chk(narrow_sel, 1'b1, "R4 narrow after full new run");
  endtask

  task automatic t_hold_and_init();
    // continues from qualified narrow state
    pulse(1'b1);
    chk(narrow_sel, 1'b1, "R6 held narrow through lol");
    hitless_en = 1'b1;
    pulse(1'b1);
    pulse(1'b0);
    chk(narrow_sel, 1'b1, "R6 hitless enable has no effect");
    // R2: level changes without a strobe do nothing
    init_en = 1'b0; narrow_req = 1'b0; lol = 1'b1;
    repeat (3) @(negedge clk);
    chk(narrow_sel, 1'b1, "R2 no change without strobe");
    lol = 1'b0;
    narrow_req = 1'b1;
    pulse(1'b0);
    chk(narrow_sel, 1'b0, "R5 init low forces wide");
    for (int i = 0; i < 9; i++) pulse(1'b0);
    chk(narrow_sel, 1'b0, "R5 stays wide with init low");
    hitless_en = 1'b0;
  endtask

  task automatic t_hitless();
    do_reset();
    narrow_req = 1'b0; init_en = 1'b1; hitless_en = 1'b1;
    pulse(1'b1);
    chk(narrow_sel, 1'b0, "R7 lol before arming ignored");
    for (int i = 0; i < 7; i++) pulse(1'b0);
    pulse(1'b1);
    chk(narrow_sel, 1'b0, "R7 seven clean strobes do not arm");
    for (int i = 0; i < 8; i++) pulse(1'b0);
    chk(narrow_sel, 1'b0, "R7 armed but still wide");
    pulse(1'b1);
    chk(narrow_sel, 1'b1, "R8 single lol triggers narrow");
    for (int i = 0; i < 3; i++) pulse(1'b0);
    pulse(1'b1);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    chk(narrow_sel, 1'b1, "R9 lol in recovery restarts run");
    pulse(1'b0);
    chk(narrow_sel, 1'b0, "R9 wide after eight clean strobes");
    pulse(1'b1);
    chk(narrow_sel, 1'b1, "R9 re-armed trigger");
    for (int i = 0; i < 8; i++) pulse(1'b0);
    chk(narrow_sel, 1'b0, "R9 second recovery to wide");
  endtask

  task automatic t_plain();
    do_reset();
    narrow_req = 1'b0; init_en = 1'b1; hitless_en = 1'b0;
    for (int i = 0; i < 10; i++) pulse(1'b0);
    chk(narrow_sel, 1'b0, "R10 wide after clean run");
    pulse(1'b1);
    chk(narrow_sel, 1'b0, "R10 wide after lol");
    pulse(1'b0);
    chk(narrow_sel, 1'b0, "R10 wide after recovery");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_restart();
    t_hold_and_init();
    t_hitless();
    t_plain();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule